// File: doc/BRIEF.md
# Edge-Sensing Interrupt Pin Controller

This block looks after eight external pins. Each pin can be used as plain general-purpose I/O. It can also act as an interrupt source that senses either a low level or selected edges. Software reaches the block through a small 16-bit register bus. Every access carries a privilege qualifier, and the configuration registers turn away user-mode accesses with a transfer error. Each pin has its own interrupt request, formed from a sticky flag and an enable bit. A separate wake output works while the clock is stopped.

Incoming pin values pass through a two-stage synchronizer. The synchronized values feed the pin-data readback and the detection logic. The wake output is different: it takes the raw pin level with no synchronizer, so an enabled level-sensing pin that goes low can restart a stopped part.

The bus is handled by a three-state machine. `BUS_IDLE` waits for a request. `BUS_IDLE -> BUS_ACK` is taken when a request is permitted, and the access is performed at that clock edge. `BUS_IDLE -> BUS_ERR` is taken when a user-mode request targets a supervisor-only word. Both `BUS_ACK -> BUS_IDLE` and `BUS_ERR -> BUS_IDLE` are unconditional, one cycle later.

Top module: `edgeport_irq`

## Requirements
- R1: After reset, the sense configuration, direction, enable, output and flag registers are all zero, so every pin is an input and no interrupt is requested. Both synchronizer stages and the previous-sample register start at all ones.
- R2: A request is accepted only in `BUS_IDLE`. Exactly one cycle later, exactly one of `bus_ack` and `bus_err` is high, for one cycle. A request present during a response cycle is ignored. `bus_rdata` carries read data during the acknowledge of a read and is zero at all other times.
- R3: Word indices 0 and 1 are supervisor-only (`bus_sup`=1). A user access to them returns `bus_err`, changes no register, and returns zero data.
- R4: Word indices 2 and 3 accept both user and supervisor accesses.
- R5: Word layout. Index 0 holds the sense configuration, 2 bits per pin, with pin i at bits [2i+1:2i]. Index 1 holds direction in [15:8] and interrupt enable in [7:0]. Index 2 holds output data in [15:8] and pin data in [7:0]. Index 3 holds flags in [15:8].
- R6: The pin-data byte is read-only, and writes to it are ignored. Bits [7:0] of index 3 are reserved: they read as zero and writes to them are ignored.
- R7: The pin data read back is the value of `pin_in` sampled two rising edges earlier.
- R8: Sense codes: 00 is low level, 01 is rising edge, 10 is falling edge, 11 is both edges. In an edge mode, a change in the synchronized value sets the flag at the next edge, three edges after the change of `pin_in`.
- R9: Edge-mode flags are sticky. Writing 1 to a flag bit at index 3 clears it. A detection in the same cycle takes priority over the clear.
- R10: In level mode, the flag takes the inverted synchronized value one cycle later. It therefore stays set, despite write-1-clear, while the pin stays low.
- R11: `irq[i]` is high exactly when flag i and enable i are both set.
- R12: While `stop` is high, no edge sets a flag.
- R13: `wake` is high, with no clock involved, whenever some pin that is enabled and in level mode has `pin_in` low.
- R14: `pin_out` follows the output-data byte, and `pin_oe` follows the direction byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop | input | 1 | Low-power stop indication; disables edge sensing |
| pin_in | input | 8 | Raw pin levels |
| pin_out | output | 8 | Output data driven to the pins |
| pin_oe | output | 8 | Output enable per pin (1 = output) |
| bus_req | input | 1 | Access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_idx | input | 2 | 16-bit word index (byte offset / 2) |
| bus_sup | input | 1 | 1 = supervisor access, 0 = user |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid with `bus_ack` |
| bus_ack | output | 1 | Access completed |
| bus_err | output | 1 | Access rejected (privilege) |
| irq | output | 8 | Per-pin interrupt request |
| wake | output | 1 | Unsynchronized low-level wake request |

## Verification
Detection is exercised with one pin in each edge mode, and each pin is pulsed both low and high. That separates rising from falling from both-edge sensing, and it shows the flags stay set after the pin returns to its idle level. A held-low level pin is driven against a write-1-clear, which tells level flags apart from sticky ones. The same edge stimulus is repeated with `stop` high to show the edges are suppressed. Wake is probed between clock edges, which shows that it bypasses the synchronizer. Bus patterns cover user against supervisor access on every word, writes to read-only and reserved bytes, and a request held through the response cycle.

// File: rtl/edgeport_pkg.sv
package edgeport_pkg;

    localparam int unsigned PINS       = 8;
    localparam int unsigned BUS_W      = 16;
    localparam int unsigned CFG_W      = 2 * PINS;
    localparam int unsigned IDX_W      = 2;
    // word indices below this limit require supervisor privilege
    localparam logic [IDX_W-1:0] SUPV_LIMIT = 2'd2;

    localparam logic [IDX_W-1:0] IDX_CFG  = 2'd0;
    localparam logic [IDX_W-1:0] IDX_DIR  = 2'd1;
    localparam logic [IDX_W-1:0] IDX_DATA = 2'd2;
    localparam logic [IDX_W-1:0] IDX_FLAG = 2'd3;

    typedef enum logic [1:0] {
        BUS_IDLE = 2'd0,
        BUS_ACK  = 2'd1,
        BUS_ERR  = 2'd2
    } bus_state_e;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_RISE = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_BOTH = 2'b11
    } sense_e;

endpackage

// File: rtl/edgeport_sync.sv
module edgeport_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [STAGES-1:0][WIDTH-1:0] stg_q;

    // idle-high reset so no edge or low level is seen before real samples arrive
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= '1;
        end else begin
            stg_q[0] <= din;
            for (int k = 1; k < int'(STAGES); k++) begin
                stg_q[k] <= stg_q[k-1];
            end
        end
    end

    assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/edgeport_detect.sv
module edgeport_detect
    import edgeport_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stop,
    input  logic [PINS-1:0]  smp,
    input  logic [CFG_W-1:0] cfg,
    input  logic [PINS-1:0]  clr,
    output logic [PINS-1:0]  flag
);

    logic [PINS-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= smp;
    end

    for (genvar i = 0; i < int'(PINS); i++) begin : g_pin
        sense_e mode;
        logic   rise;
        logic   fall;
        logic   hit;
        logic   flag_q;

        assign mode = sense_e'(cfg[2*i +: 2]);
        assign rise = smp[i] & ~prev_q[i];
        assign fall = ~smp[i] & prev_q[i];

        always_comb begin
            unique case (mode)
                SENSE_RISE: hit = rise;
                SENSE_FALL: hit = fall;
                SENSE_BOTH: hit = rise | fall;
                default:    hit = 1'b0;
            endcase
            if (stop) hit = 1'b0;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                flag_q <= 1'b0;
            else if (mode == SENSE_LOW) flag_q <= ~smp[i];
            else                       flag_q <= hit | (flag_q & ~clr[i]);
        end

        assign flag[i] = flag_q;

        // R8: a synchronized rising edge in rising mode sets the flag next cycle
        a_r8_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
            (mode == SENSE_RISE && smp[i] && !prev_q[i] && !stop) |=> flag_q);

        // R10: level flag tracks the inverted synchronized sample
        a_r10_level_follows: assert property (@(posedge clk) disable iff (!rst_n)
            (mode == SENSE_LOW) |=> (flag_q == !$past(smp[i])));

        // R12: stop prevents an edge-mode flag from becoming set
        a_r12_stop_blocks_edge: assert property (@(posedge clk) disable iff (!rst_n)
            (stop && mode != SENSE_LOW && !flag_q) |=> !flag_q);
    end

endmodule

// File: rtl/edgeport_bus.sv
module edgeport_bus
    import edgeport_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic             sup,
    input  logic [BUS_W-1:0] wdata,
    input  logic [PINS-1:0]  pin_smp,
    input  logic [PINS-1:0]  flag,
    output logic [BUS_W-1:0] rdata,
    output logic             ack,
    output logic             err,
    output logic [CFG_W-1:0] cfg,
    output logic [PINS-1:0]  dir,
    output logic [PINS-1:0]  ien,
    output logic [PINS-1:0]  dout,
    output logic [PINS-1:0]  clr
);

    bus_state_e      state_q, state_nx;
    logic            accept;
    logic            deny;
    logic            grant;
    logic [BUS_W-1:0] rd_mux;

    assign accept = (state_q == BUS_IDLE) && req;
    assign deny   = accept && !sup && (idx < SUPV_LIMIT);
    assign grant  = accept && !deny;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            BUS_IDLE: if (req) state_nx = deny ? BUS_ERR : BUS_ACK;
            BUS_ACK:  state_nx = BUS_IDLE;
            BUS_ERR:  state_nx = BUS_IDLE;
            default:  state_nx = BUS_IDLE;
        endcase
    end

    always_comb begin
        unique case (idx)
            IDX_CFG:  rd_mux = cfg;
            IDX_DIR:  rd_mux = {dir, ien};
            IDX_DATA: rd_mux = {dout, pin_smp};
            default:  rd_mux = {flag, {PINS{1'b0}}};
        endcase
    end

    assign clr = (grant && we && idx == IDX_FLAG) ? wdata[BUS_W-1:PINS] : '0;

    // outputs and register file
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg   <= '0;
            dir   <= '0;
            ien   <= '0;
            dout  <= '0;
            rdata <= '0;
        end else begin
            rdata <= (grant && !we) ? rd_mux : '0;
            if (grant && we) begin
                unique case (idx)
                    IDX_CFG:  cfg <= wdata;
                    IDX_DIR:  begin
                        dir <= wdata[BUS_W-1:PINS];
                        ien <= wdata[PINS-1:0];
                    end
                    IDX_DATA: dout <= wdata[BUS_W-1:PINS];
                    default:  ;
                endcase
            end
        end
    end

    assign ack = (state_q == BUS_ACK);
    assign err = (state_q == BUS_ERR);

    // R2: an accepted request is answered once on the next cycle
    a_r2_one_response: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BUS_IDLE && req) |=> (ack ^ err));

    // R2: responses never come back to back
    a_r2_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        (ack || err) |=> (!ack && !err));

    // R3: user access to a supervisor word errors and writes nothing
    a_r3_user_denied: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BUS_IDLE && req && !sup && idx < SUPV_LIMIT)
        |=> (err && $stable(cfg) && $stable(dir) && $stable(ien) && rdata == '0));

endmodule

// File: rtl/edgeport_irq.sv
module edgeport_irq
    import edgeport_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        stop,
    input  logic [7:0]  pin_in,
    output logic [7:0]  pin_out,
    output logic [7:0]  pin_oe,
    input  logic        bus_req,
    input  logic        bus_we,
    input  logic [1:0]  bus_idx,
    input  logic        bus_sup,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    output logic        bus_ack,
    output logic        bus_err,
    output logic [7:0]  irq,
    output logic        wake
);

    logic [PINS-1:0]  smp;
    logic [PINS-1:0]  flag;
    logic [PINS-1:0]  clr;
    logic [PINS-1:0]  dir;
    logic [PINS-1:0]  ien;
    logic [PINS-1:0]  dout;
    logic [CFG_W-1:0] cfg;
    logic [PINS-1:0]  lvl_mask;

    edgeport_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pin_in),
        .dout (smp)
    );

    edgeport_detect u_detect (
        .clk  (clk),
        .rst_n(rst_n),
        .stop (stop),
        .smp  (smp),
        .cfg  (cfg),
        .clr  (clr),
        .flag (flag)
    );

    edgeport_bus u_bus (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (bus_req),
        .we     (bus_we),
        .idx    (bus_idx),
        .sup    (bus_sup),
        .wdata  (bus_wdata),
        .pin_smp(smp),
        .flag   (flag),
        .rdata  (bus_rdata),
        .ack    (bus_ack),
        .err    (bus_err),
        .cfg    (cfg),
        .dir    (dir),
        .ien    (ien),
        .dout   (dout),
        .clr    (clr)
    );

    for (genvar i = 0; i < int'(PINS); i++) begin : g_lvl
        assign lvl_mask[i] = (cfg[2*i +: 2] == SENSE_LOW);
    end

    assign irq     = flag & ien;
    assign pin_out = dout;
    assign pin_oe  = dir;
    // raw pin path, no synchronizer: must work with the clock stopped
    assign wake    = |(ien & lvl_mask & ~pin_in);

endmodule

// File: tb/test_edgeport_irq.sv
module test_edgeport_irq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stop = 1'b0;
    logic [7:0]  pin_in = 8'hFF;
    logic [7:0]  pin_out, pin_oe, irq;
    logic        bus_req = 1'b0, bus_we = 1'b0, bus_sup = 1'b0;
    logic [1:0]  bus_idx = 2'd0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        bus_ack, bus_err, wake;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    edgeport_irq i_edgeport_irq (
        .clk(clk), .rst_n(rst_n), .stop(stop), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe),
        .bus_req(bus_req), .bus_we(bus_we), .bus_idx(bus_idx), .bus_sup(bus_sup),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ack(bus_ack), .bus_err(bus_err), .irq(irq), .wake(wake)
    );

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    // behavioural reference model
    logic [7:0]  m_s1 = 8'hFF, m_s2 = 8'hFF, m_prev = 8'hFF, m_flag = 8'h0;
    logic [7:0]  m_dir = 8'h0, m_ien = 8'h0, m_dout = 8'h0;
    logic [15:0] m_cfg = 16'h0, m_rdata = 16'h0;
    int          m_st = 0;   // 0 idle, 1 ack, 2 err

    always @(posedge clk) begin : model
        logic [7:0]  nf, clrv;
        logic [15:0] rd;
        bit          acc, den;
        int          md;
        if (!rst_n) begin
            m_s1 = 8'hFF; m_s2 = 8'hFF; m_prev = 8'hFF; m_flag = 8'h0;
            m_dir = 8'h0; m_ien = 8'h0; m_dout = 8'h0; m_cfg = 16'h0;
            m_rdata = 16'h0; m_st = 0;
        end else begin
            acc  = (m_st == 0) && bus_req;
            den  = acc && !bus_sup && (bus_idx < 2);
            clrv = (acc && !den && bus_we && bus_idx == 3) ? bus_wdata[15:8] : 8'h0;
            for (int i = 0; i < 8; i++) begin
                md = int'(m_cfg[2*i +: 2]);
                if (md == 0) nf[i] = !m_s2[i];
                else begin
                    bit r, f, h;
                    r = m_s2[i] && !m_prev[i];
                    f = !m_s2[i] && m_prev[i];
                    h = (md == 1 && r) || (md == 2 && f) || (md == 3 && (r || f));
                    if (stop) h = 0;
                    nf[i] = h || (m_flag[i] && !clrv[i]);
                end
            end
            case (bus_idx)
                2'd0:    rd = m_cfg;
                2'd1:    rd = {m_dir, m_ien};
                2'd2:    rd = {m_dout, m_s2};
                default: rd = {m_flag, 8'h00};
            endcase
            m_rdata = (acc && !den && !bus_we) ? rd : 16'h0;
            if (acc && !den && bus_we) begin
                if (bus_idx == 0) m_cfg = bus_wdata;
                if (bus_idx == 1) begin m_dir = bus_wdata[15:8]; m_ien = bus_wdata[7:0]; end
                if (bus_idx == 2) m_dout = bus_wdata[15:8];
            end
            m_st   = acc ? (den ? 2 : 1) : 0;
            m_flag = nf;
            m_prev = m_s2;
            m_s2   = m_s1;
            m_s1   = pin_in;
        end
    end

    // cycle-by-cycle comparison away from the active edge
    always @(negedge clk) begin
        logic [7:0] lvl;
        if (rst_n && !done) begin
            for (int i = 0; i < 8; i++) lvl[i] = (m_cfg[2*i +: 2] == 2'b00);
            chk("R14 pin_out", {8'h0, pin_out}, {8'h0, m_dout});
            chk("R14 pin_oe", {8'h0, pin_oe}, {8'h0, m_dir});
            chk("R11 irq", {8'h0, irq}, {8'h0, m_flag & m_ien});
            chk("R13 wake", {15'h0, wake}, {15'h0, |(m_ien & lvl & ~pin_in)});
            chk("R2 ack", {15'h0, bus_ack}, {15'h0, m_st == 1});
            chk("R3 err", {15'h0, bus_err}, {15'h0, m_st == 2});
            chk("R5 rdata", bus_rdata, m_rdata);
        end
    end

    task automatic access(input bit we, input logic [1:0] idx, input bit sup,
                          input logic [15:0] wd, output logic [15:0] rd, output logic e);
        @(posedge clk); #2;
        bus_req = 1'b1; bus_we = we; bus_idx = idx; bus_sup = sup; bus_wdata = wd;
        @(posedge clk); #2;
        bus_req = 1'b0;
        rd = bus_rdata;
        e  = bus_err;
    endtask

    task automatic set_pins(input logic [7:0] v);
        @(posedge clk); #2;
        pin_in = v;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin : watchdog
        #2000000;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin : stim
        logic [15:0] rd;
        logic        e;
        wait_cyc(3); #2;
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 pin_oe", {8'h0, pin_oe}, 16'h0);
        chk("R1 irq", {8'h0, irq}, 16'h0);
        access(0, 2'd0, 1, 16'h0, rd, e);  chk("R1 cfg", rd, 16'h0000);
        access(0, 2'd1, 1, 16'h0, rd, e);  chk("R1 dir/ien", rd, 16'h0000);
        access(0, 2'd3, 0, 16'h0, rd, e);  chk("R1 flags", rd, 16'h0000);

        // R3 user denied on supervisor words
        access(1, 2'd0, 0, 16'hFFFF, rd, e); chk("R3 err on write", {15'h0, e}, 16'h1);
        access(0, 2'd1, 0, 16'h0, rd, e);   chk("R3 err on read", {15'h0, e}, 16'h1);
        chk("R3 zero data", rd, 16'h0);
        access(0, 2'd0, 1, 16'h0, rd, e);   chk("R3 cfg unchanged", rd, 16'h0000);

        // R4 / R14 user output data, R6 read-only pin byte
        access(1, 2'd2, 0, 16'hA533, rd, e); chk("R4 user ok", {15'h0, e}, 16'h0);
        chk("R14 pin_out", {8'h0, pin_out}, 16'h00A5);
        access(0, 2'd2, 0, 16'h0, rd, e);   chk("R6 pin byte read-only", rd, 16'hA5FF);
        access(1, 2'd3, 0, 16'h00FF, rd, e);
        access(0, 2'd3, 0, 16'h0, rd, e);   chk("R6 reserved zero", rd, 16'h0000);

        // R5 layout: direction and enable
        access(1, 2'd1, 1, 16'hF0FF, rd, e);
        access(0, 2'd1, 1, 16'h0, rd, e);   chk("R5 dir/ien", rd, 16'hF0FF);
        chk("R14 pin_oe", {8'h0, pin_oe}, 16'h00F0);

        // R7 synchronizer readback
        set_pins(8'h5F); wait_cyc(3);
        access(0, 2'd2, 0, 16'h0, rd, e);   chk("R7 pin data", rd[7:0], 16'h005F);
        set_pins(8'hFF); wait_cyc(3);

        // R8 edge modes: pin0 rise, pin1 fall, pin2 both
        access(1, 2'd0, 1, 16'h0039, rd, e);
        set_pins(8'hF9); wait_cyc(4);
        access(0, 2'd3, 0, 16'h0, rd, e);   chk("R8 falling edges", rd, 16'h0600);
        set_pins(8'hFF); wait_cyc(4);
        set_pins(8'hFE); wait_cyc(4);
        set_pins(8'hFF); wait_cyc(4);
        access(0, 2'd3, 0, 16'h0, rd, e);   chk("R8 rising edges sticky", rd, 16'h0700);

        // R9 write-one-clear
        access(1, 2'd3, 0, 16'h0100, rd, e);
        access(0, 2'd3, 0, 16'h0, rd, e);   chk("R9 clear pin0", rd, 16'h0600);
        access(1, 2'd3, 0, 16'hFF00, rd, e);
        access(0, 2'd3, 0, 16'h0, rd, e);   chk("R9 clear all", rd, 16'h0000);

        // R10 level mode on pin3, R13 wake without clock
        @(posedge clk); #2;
        pin_in = 8'hF7;
        #1;
        chk("R13 wake raw", {15'h0, wake}, 16'h1);
        wait_cyc(4);
        access(1, 2'd3, 0, 16'h0800, rd, e);
        access(0, 2'd3, 0, 16'h0, rd, e);   chk("R10 level held", rd, 16'h0800);
        chk("R11 irq level", {8'h0, irq}, 16'h0008);
        access(1, 2'd1, 1, 16'hF000, rd, e);
        #1;
        chk("R11 disabled", {8'h0, irq}, 16'h0000);
        chk("R13 wake disabled", {15'h0, wake}, 16'h0);
        access(1, 2'd1, 1, 16'hF0FF, rd, e);
        set_pins(8'hFF); wait_cyc(4);
        access(0, 2'd3, 0, 16'h0, rd, e);   chk("R10 level released", rd, 16'h0000);

        // R12 stop suppresses edges
        @(posedge clk); #2; stop = 1'b1;
        set_pins(8'hF9); wait_cyc(4);
        set_pins(8'hFF); wait_cyc(4);
        access(0, 2'd3, 0, 16'h0, rd, e);   chk("R12 no edge flags", rd, 16'h0000);
        @(posedge clk); #2; stop = 1'b0;

        // R2 request held through the response cycle is ignored there
        @(posedge clk); #2;
        bus_req = 1'b1; bus_we = 1'b0; bus_idx = 2'd2; bus_sup = 1'b0;
        @(posedge clk); #2;
        chk("R2 ack", {15'h0, bus_ack}, 16'h1);
        @(posedge clk); #2;
        bus_req = 1'b0;
        chk("R2 held req ignored", {14'h0, bus_ack, bus_err}, 16'h0);
        wait_cyc(3);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule